// File: doc/BRIEF.md
# Four-Phase Shared Buffer SRAM Arbiter

This block shares one single-port buffer SRAM among three on-chip clients: the USB serial engine, the disk transfer engine and the microcontroller. It does not arbitrate on request. A free-running phase counter splits time into four non-overlapping slots of one clock each, and they repeat in a fixed order. Each slot belongs to one client. Slot 0 belongs to the USB engine, slot 1 to the disk path and slot 2 to the microcontroller. Slot 3 belongs to no client and is always idle.

Every client has a 32-bit staging latch next to the SRAM. A client posts an access (address, write flag and write word) into its latch at any time outside its slot. The latch holds the access until the client's own slot comes round, and then drives the SRAM port for that one cycle. The SRAM is synchronous: read data leaves the memory one cycle after the slot. The block loads it into the client's read latch on the following edge and pulses a valid flag. Each client sees a busy flag while its access waits. The current phase number is visible as an output.

Top module: `sram_phase_arbiter`

## Requirements
- R1: After reset `phase` is 0. On every clock it advances by one and wraps from NUM_PHASES-1 to 0.
- R2: The SRAM is enabled only in phase p when p < NUM_CLIENTS, and then only for client p (0 = USB engine, 1 = disk path, 2 = microcontroller). In every phase numbered NUM_CLIENTS or higher (phase 3 by default), `mem_en` and `mem_we` stay low.
- R3: A request (`cl_req[i]` high for one cycle) seen while `cl_busy[i]` is low is captured: the address, write flag and write word are latched, and `cl_busy[i]` is high from the next cycle.
- R4: A request seen while `cl_busy[i]` is high is ignored. The access later driven to the SRAM uses the earlier latched values, and the ignored address is never accessed.
- R5: A latched access is issued in the first phase equal to i after the capturing edge. In that cycle the block drives `mem_en`=1, `mem_addr`, `mem_we` and (for writes) `mem_wdata` from the latch. `cl_busy[i]` is low from the next cycle. A request captured in the client's own phase therefore waits a full rotation.
- R6: If a client has no latched access during its own phase, that phase leaves the SRAM idle (`mem_en`=0, `mem_we`=0).
- R7: For a read issued in cycle k, `cl_rdata[i]` takes the word read from `mem_rdata` and `cl_rvalid[i]` is high for exactly one cycle, cycle k+2. `cl_rdata[i]` then holds that word until the client's next read completes.
- R8: A write never raises `cl_rvalid`.
- R9: While `rst_n` is low at a clock edge, `phase`, `cl_busy`, `cl_rvalid` and `mem_en` are all forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cl_req | input | NUM_CLIENTS | Per-client one-cycle access request |
| cl_we | input | NUM_CLIENTS | Per-client write flag (1 = write, 0 = read) |
| cl_addr | input | NUM_CLIENTS x ADDR_W | Per-client word address |
| cl_wdata | input | NUM_CLIENTS x DATA_W | Per-client write word |
| cl_busy | output | NUM_CLIENTS | Access latched and not yet issued |
| cl_rvalid | output | NUM_CLIENTS | One-cycle pulse when read latch is loaded |
| cl_rdata | output | NUM_CLIENTS x DATA_W | Per-client read latch |
| phase | output | PH_W | Current phase number |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | DATA_W | SRAM write word |
| mem_rdata | input | DATA_W | SRAM read word, valid one cycle after a read |

## Verification
The bench uses the default parameters: three clients, four phases, 9-bit word addresses and 32-bit words. With four phases and three clients, the idle slot recurs every fourth cycle, and a request posted in any of the four phases lands at a different distance from its grant, from one cycle up to a full rotation. The small address range lets the mixed traffic hit the same words often, so reads after other clients' writes are exercised.

// File: rtl/sram_arb_pkg.sv
// Package: shared client identities and helpers for the phase arbiter.
// Assumes clients are numbered in the order of the slots they own.
package sram_arb_pkg;

    // Client index equals the phase that client owns.
    typedef enum int unsigned {
        CL_USB  = 0,
        CL_DISK = 1,
        CL_MCU  = 2
    } client_e;

    localparam int unsigned DEF_CLIENTS = 3;

    // True when a phase number is not owned by any client.
    function automatic bit phase_unowned(int unsigned ph, int unsigned nclients);
        return ph >= nclients;
    endfunction

endpackage

// File: rtl/arb_phase_seq.sv
// Module: free-running phase counter.
// Counts 0..NUM_PHASES-1 and wraps; one phase per clock.
// Assumes NUM_PHASES >= 2.
module arb_phase_seq #(
    parameter int unsigned NUM_PHASES = 4,
    parameter int unsigned PH_W       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

    // Advance the phase each cycle, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

endmodule

// File: rtl/arb_client_slot.sv
// Module: one client's staging latch and read-return latch.
// Captures a request while idle, frees it in the granted phase, and loads
// the SRAM word one cycle after a read grant.
// Assumes the SRAM returns read data exactly one cycle after enable.
module arb_client_slot #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              lat_we,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic rd_wait;

    // Hold a posted access until its slot; requests while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (busy && grant) begin
            busy      <= 1'b0;
        end else if (req && !busy) begin
            busy      <= 1'b1;
            lat_we    <= we;
            lat_addr  <= addr;
            lat_wdata <= wdata;
        end
    end

    // Mark a read whose data arrives from the SRAM in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_wait <= 1'b0;
        else        rd_wait <= busy && grant && !lat_we;
    end

    // Load the read latch and pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_wait;
            if (rd_wait) rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/arb_grant_mux.sv
// Module: steers the owning client's latch onto the SRAM port.
// Purely combinational; drives nothing in unowned or empty phases.
// Assumes NUM_CLIENTS <= NUM_PHASES.
module arb_grant_mux #(
    parameter int unsigned NUM_CLIENTS = 3,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned PH_W        = 2
) (
    input  logic [PH_W-1:0]                    phase,
    input  logic [NUM_CLIENTS-1:0]             busy,
    input  logic [NUM_CLIENTS-1:0]             lat_we,
    input  logic [NUM_CLIENTS-1:0][ADDR_W-1:0] lat_addr,
    input  logic [NUM_CLIENTS-1:0][DATA_W-1:0] lat_wdata,
    output logic                               mem_en,
    output logic                               mem_we,
    output logic [ADDR_W-1:0]                  mem_addr,
    output logic [DATA_W-1:0]                  mem_wdata
);

    // Select the slot owner's pending access, if any.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int i = 0; i < NUM_CLIENTS; i++) begin
            if (busy[i] && (int'(phase) == i)) begin
                mem_en    = 1'b1;
                mem_we    = lat_we[i];
                mem_addr  = lat_addr[i];
                mem_wdata = lat_wdata[i];
            end
        end
    end

endmodule

// File: rtl/sram_phase_arbiter.sv
// Module: time-slot arbiter sharing one single-port SRAM among clients.
// Phase p of a fixed rotation belongs to client p; phases beyond the client
// count stay idle. Each client posts into its own latch outside its slot.
// Assumes a synchronous SRAM with one-cycle read latency.
module sram_phase_arbiter #(
    parameter int unsigned NUM_CLIENTS = sram_arb_pkg::DEF_CLIENTS,
    parameter int unsigned NUM_PHASES  = 4,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned PH_W       = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_CLIENTS-1:0]             cl_req,
    input  logic [NUM_CLIENTS-1:0]             cl_we,
    input  logic [NUM_CLIENTS-1:0][ADDR_W-1:0] cl_addr,
    input  logic [NUM_CLIENTS-1:0][DATA_W-1:0] cl_wdata,
    output logic [NUM_CLIENTS-1:0]             cl_busy,
    output logic [NUM_CLIENTS-1:0]             cl_rvalid,
    output logic [NUM_CLIENTS-1:0][DATA_W-1:0] cl_rdata,
    output logic [PH_W-1:0]                    phase,
    output logic                               mem_en,
    output logic                               mem_we,
    output logic [ADDR_W-1:0]                  mem_addr,
    output logic [DATA_W-1:0]                  mem_wdata,
    input  logic [DATA_W-1:0]                  mem_rdata
);

    logic [NUM_CLIENTS-1:0]             lat_we;
    logic [NUM_CLIENTS-1:0][ADDR_W-1:0] lat_addr;
    logic [NUM_CLIENTS-1:0][DATA_W-1:0] lat_wdata;

    arb_phase_seq #(
        .NUM_PHASES (NUM_PHASES),
        .PH_W       (PH_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    for (genvar g = 0; g < NUM_CLIENTS; g++) begin : g_slot
        arb_client_slot #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .grant     (phase == PH_W'(g)),
            .req       (cl_req[g]),
            .we        (cl_we[g]),
            .addr      (cl_addr[g]),
            .wdata     (cl_wdata[g]),
            .mem_rdata (mem_rdata),
            .busy      (cl_busy[g]),
            .lat_we    (lat_we[g]),
            .lat_addr  (lat_addr[g]),
            .lat_wdata (lat_wdata[g]),
            .rdata     (cl_rdata[g]),
            .rvalid    (cl_rvalid[g])
        );
    end

    arb_grant_mux #(
        .NUM_CLIENTS (NUM_CLIENTS),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PH_W        (PH_W)
    ) u_mux (
        .phase     (phase),
        .busy      (cl_busy),
        .lat_we    (lat_we),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/arb_checker.sv
// Module: temporal checks on the phase arbiter's ports, bound to every
// instance. Assumes the SRAM read latency of one cycle.
module arb_checker #(
    parameter int unsigned NUM_CLIENTS = 3,
    parameter int unsigned NUM_PHASES  = 4,
    parameter int unsigned PH_W        = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CLIENTS-1:0] cl_req,
    input logic [NUM_CLIENTS-1:0] cl_busy,
    input logic [NUM_CLIENTS-1:0] cl_rvalid,
    input logic [PH_W-1:0]        phase,
    input logic                   mem_en,
    input logic                   mem_we
);

    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |=> (phase == '0));

    a_r1_phase_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST) |=> (int'(phase) == int'($past(phase)) + 1));

    a_r2_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sram_arb_pkg::phase_unowned(int'(phase), NUM_CLIENTS) |-> !mem_en);

    a_r6_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_cl
        a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
            (cl_req[i] && !cl_busy[i]) |=> cl_busy[i]);

        a_r5_serve: assert property (@(posedge clk) disable iff (!rst_n)
            (cl_busy[i] && int'(phase) == i) |-> mem_en);

        a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_en && int'(phase) == i) |=> !cl_busy[i]);

        a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            cl_rvalid[i] |=> !cl_rvalid[i]);

        a_r7_timing: assert property (@(posedge clk) disable iff (!rst_n)
            cl_rvalid[i] |-> $past(mem_en && !mem_we && int'(phase) == i, 2));

        a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_en && mem_we && int'(phase) == i) |=> ##1 !cl_rvalid[i]);
    end

endmodule

bind sram_phase_arbiter arb_checker #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .NUM_PHASES  (NUM_PHASES),
    .PH_W        (PH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cl_req    (cl_req),
    .cl_busy   (cl_busy),
    .cl_rvalid (cl_rvalid),
    .phase     (phase),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/sim_sram_phase_arbiter.sv
module sim_sram_phase_arbiter;

    localparam int NC = 3;
    localparam int NP = 4;
    localparam int AW = 9;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n;
    logic [NC-1:0]          cl_req, cl_we, cl_busy, cl_rvalid;
    logic [NC-1:0][AW-1:0]  cl_addr;
    logic [NC-1:0][DW-1:0]  cl_wdata, cl_rdata;
    logic [1:0]             phase;
    logic                   mem_en, mem_we;
    logic [AW-1:0]          mem_addr;
    logic [DW-1:0]          mem_wdata, mem_rdata;

    sram_phase_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cl_req(cl_req), .cl_we(cl_we),
        .cl_addr(cl_addr), .cl_wdata(cl_wdata), .cl_busy(cl_busy),
        .cl_rvalid(cl_rvalid), .cl_rdata(cl_rdata), .phase(phase),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Behavioural single-port SRAM with one-cycle read latency.
    logic [DW-1:0] mem_model [0:(1<<AW)-1];
    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_model[i] = 32'h5A00_0000 | i;
        mem_rdata = '0;
    end
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_model[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_model[mem_addr];
        end
    end

    int cyc = 0;
    int exp_ph = 0;
    always @(posedge clk) begin
        cyc    <= cyc + 1;
        exp_ph <= !rst_n ? 0 : (exp_ph + 1) % NP;
    end

    int total = 0;
    int bad = 0;
    bit mon_on = 0;
    bit done = 0;

    typedef struct { int due; int cl; logic [AW-1:0] addr; logic we; logic [DW-1:0] wd; string tag; } acc_t;
    typedef struct { int due; int cl; logic [DW-1:0] data; } rd_t;
    acc_t acc_q[$];
    rd_t  rd_q[$];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: post an access and push its expected SRAM transaction.
    task automatic issue(int cl, int addr, bit we, logic [DW-1:0] wd, string tag);
        acc_t e;
        int d;
        d = ((cl - int'(phase) - 1 + 2 * NP) % NP) + 1;
        e.due = cyc + d; e.cl = cl; e.addr = AW'(addr); e.we = we; e.wd = wd; e.tag = tag;
        acc_q.push_back(e);
        cl_req[cl]   = 1'b1;
        cl_we[cl]    = we;
        cl_addr[cl]  = AW'(addr);
        cl_wdata[cl] = wd;
    endtask

    task automatic tick();
        @(negedge clk);
        cl_req = '0;
    endtask

    // Monitor: compare SRAM traffic and read returns against the queues.
    int prev_gr = -1;
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            int idx;
            chk(int'(phase) == exp_ph, "R1", "phase", phase, exp_ph);
            if (prev_gr >= 0)
                chk(!cl_busy[prev_gr], "R5", "busy after grant", cl_busy[prev_gr], 0);
            prev_gr = -1;
            idx = -1;
            foreach (acc_q[k]) if (acc_q[k].due == cyc) idx = k;
            if (int'(phase) >= NC)
                chk(!mem_en && !mem_we, "R2", "idle slot access", {mem_en, mem_we}, 0);
            if (mem_en) begin
                if (idx < 0) begin
                    chk(0, "R4", "unexpected access addr", mem_addr, 0);
                end else begin
                    chk(int'(phase) == acc_q[idx].cl, "R2", "slot owner", phase, acc_q[idx].cl);
                    chk(mem_addr == acc_q[idx].addr && mem_we == acc_q[idx].we,
                        acc_q[idx].tag, "addr/we", {mem_we, mem_addr}, {acc_q[idx].we, acc_q[idx].addr});
                    if (acc_q[idx].we)
                        chk(mem_wdata == acc_q[idx].wd, acc_q[idx].tag, "wdata", mem_wdata, acc_q[idx].wd);
                    else begin
                        rd_t r;
                        r.due = cyc + 2; r.cl = acc_q[idx].cl; r.data = mem_model[mem_addr];
                        rd_q.push_back(r);
                    end
                    prev_gr = acc_q[idx].cl;
                    acc_q.delete(idx);
                end
            end else if (idx >= 0) begin
                chk(0, "R5", "missed access addr", 0, acc_q[idx].addr);
                acc_q.delete(idx);
            end else if (int'(phase) < NC) begin
                chk(!mem_we, "R6", "empty slot we", mem_we, 0);
            end
            for (int c = 0; c < NC; c++) begin
                int j;
                j = -1;
                foreach (rd_q[k]) if (rd_q[k].due == cyc && rd_q[k].cl == c) j = k;
                if (j >= 0) begin
                    chk(cl_rvalid[c], "R7", "rvalid", cl_rvalid[c], 1);
                    chk(cl_rdata[c] == rd_q[j].data, "R7", "rdata", cl_rdata[c], rd_q[j].data);
                    rd_q.delete(j);
                end else if (cl_rvalid[c]) begin
                    chk(0, "R8", "stray rvalid", 1, 0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cl_req = '0; cl_we = '0; cl_addr = '0; cl_wdata = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(phase == 0, "R9", "phase", phase, 0);
        chk(cl_busy == 0 && cl_rvalid == 0, "R9", "busy/rvalid", {cl_busy, cl_rvalid}, 0);
        chk(!mem_en && !mem_we, "R9", "mem_en", mem_en, 0);
        rst_n = 1'b1;
        mon_on = 1;
        repeat (6) tick();                       // R1, R6 on idle rotation

        // R3, R5: three clients post writes in the same cycle.
        issue(0, 5, 1, 32'hAAAA_0001, "R5");
        issue(1, 6, 1, 32'hBBBB_0002, "R5");
        issue(2, 7, 1, 32'hCCCC_0003, "R5");
        tick();
        chk(cl_busy == 3'b111, "R3", "busy after post", cl_busy, 3'b111);
        repeat (6) tick();
        chk(cl_busy == 3'b000, "R5", "busy cleared", cl_busy, 0);

        // R5: a request posted in the owner's own phase waits a full rotation.
        while (phase != 2'd0) tick();
        issue(0, 10, 1, 32'h1234_5678, "R5 own-phase");
        tick();
        repeat (5) tick();

        // R7: read back all three words.
        issue(0, 5, 0, '0, "R7");
        issue(1, 6, 0, '0, "R7");
        issue(2, 7, 0, '0, "R7");
        tick();
        repeat (8) tick();
        chk(cl_rdata[0] == 32'hAAAA_0001, "R7", "held rdata c0", cl_rdata[0], 32'hAAAA_0001);
        chk(cl_rdata[1] == 32'hBBBB_0002, "R7", "held rdata c1", cl_rdata[1], 32'hBBBB_0002);
        chk(cl_rdata[2] == 32'hCCCC_0003, "R7", "held rdata c2", cl_rdata[2], 32'hCCCC_0003);

        // R8: a write leaves the read latch untouched.
        issue(2, 8, 1, 32'h0BAD_F00D, "R8");
        tick();
        repeat (6) tick();
        chk(cl_rdata[2] == 32'hCCCC_0003, "R8", "rdata after write", cl_rdata[2], 32'hCCCC_0003);

        // R4: a second post while busy is dropped.
        issue(1, 20, 1, 32'h7777_0020, "R4");
        tick();
        chk(cl_busy[1], "R4", "busy before second post", cl_busy[1], 1);
        cl_req[1] = 1'b1; cl_we[1] = 1'b1; cl_addr[1] = 9'd21; cl_wdata[1] = 32'hDEAD_0021;
        tick();
        repeat (6) tick();
        issue(1, 21, 0, '0, "R4");
        tick();
        repeat (6) tick();
        chk(cl_rdata[1] == 32'h5A00_0015, "R4", "dropped word untouched", cl_rdata[1], 32'h5A00_0015);
        issue(1, 20, 0, '0, "R4");
        tick();
        repeat (6) tick();
        chk(cl_rdata[1] == 32'h7777_0020, "R4", "first word kept", cl_rdata[1], 32'h7777_0020);

        // Mixed traffic sweep over a small address range (R2, R5, R7).
        for (int n = 0; n < 400; n++) begin
            for (int c = 0; c < NC; c++)
                if (!cl_busy[c] && ($urandom % 3 == 0))
                    issue(c, int'($urandom % 16), bit'($urandom % 2), $urandom, "R5 sweep");
            tick();
        end
        repeat (12) tick();
        chk(acc_q.size() == 0, "R5", "accesses left", acc_q.size(), 0);
        chk(rd_q.size() == 0, "R7", "reads left", rd_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule